// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Controller

A synchronous, clock-sampled model of the control logic inside a byte-wide parallel EEPROM. A host drives active-low chip enable, write enable and output enable, an address and a data byte. Each write strobe loads one byte into a page buffer, and the block collects these loads into a single page. When the strobe has stayed inactive long enough after the last load, the block starts an internal write. After a fixed programming time it commits every loaded byte to the array at once.

While the internal write runs, a read returns a status byte instead of array data. Bit 7 is the complement of bit 7 of the last byte loaded. Bit 6 flips after every read. A separate busy pin is modelled as an output enable plus a constant low level. An active-low protect input blocks reads and writes, and it abandons any load or internal write in progress. All timings are parameters counted in clock cycles. The address width is a parameter. The default is 11 bits so that the default array stays small; a full-size part uses 15 bits.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After rst_ni is released, data_oe_o and rdy_oe_o are 0 and every array byte reads 0xFF.
- R2: addr_i[OFF_W-1:0] (OFF_W=6) selects the byte in a 64-byte page, and the bits above select the page. The page is taken from the first accepted strobe of a load sequence. Later strobes in the same sequence use only their offset bits.
- R3: A write strobe is active while ce_ni=0, we_ni=0 and oe_ni=1. Its address is taken on the cycle it becomes active, and its data on the last active cycle. Strobes with oe_ni=0, or that start during an internal write, have no effect.
- R4: Within a load sequence, a strobe that starts more than WIN_CYC cycles after the previous accepted strobe start is ignored.
- R5: The internal write begins after the strobe has been inactive for START_CYC cycles following the last data capture. It lasts PROG_CYC cycles and then writes all loaded bytes. Unloaded bytes of the page keep their contents, and an offset loaded twice keeps the later value.
- R6: A read during the internal write returns ~b7 on data_o[7], where b7 is bit 7 of the last loaded byte. data_o[5:0] is 0.
- R7: During the internal write, data_o[6] is 1 on the first read and inverts after each completed read.
- R8: rdy_oe_o goes to 1 on the first accepted strobe and back to 0 when the internal write ends. rdy_o is always 0.
- R9: While prot_ni=0, data_oe_o is 0 and strobes are ignored. A load sequence or internal write in progress is dropped and leaves the array unchanged.
- R10: With ce_ni=0, oe_ni=0, we_ni=1 and prot_ni=1, data_oe_o is 1. Outside an internal write, data_o equals the array byte at addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| prot_ni | input | 1 | Read/program protect, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or busy status |
| data_oe_o | output | 1 | Data bus drive enable |
| rdy_o | output | 1 | Busy pin level (always low) |
| rdy_oe_o | output | 1 | Busy pin drive enable; 0 means high impedance |

## Verification
The assertions assume that control inputs are stable between clock edges. They also assume the host never opens a read and a write strobe together, so a status byte is always followed by a well-defined end of read. The bench changes every input only at the falling clock edge. It keeps write strobes and reads in separate, non-overlapping transactions, and it holds data_i for the whole strobe. The protect input is toggled only between transactions.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/eeprom_strobe_det.sv
module eeprom_strobe_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic rd_i,
  output logic stb_start_o,
  output logic stb_end_o,
  output logic rd_end_o
);
  logic stb_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      stb_q <= stb_i;
      rd_q  <= rd_i;
    end
  end

  assign stb_start_o = stb_i & ~stb_q;
  assign stb_end_o   = ~stb_i & stb_q;
  assign rd_end_o    = ~rd_i & rd_q;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int OFF_W = 6,
  localparam int PAGE_BYTES = 1 << OFF_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           wr_i,
  input  logic [OFF_W-1:0]               off_i,
  input  logic [7:0]                     data_i,
  output logic [PAGE_BYTES-1:0][7:0]     data_o,
  output logic [PAGE_BYTES-1:0]          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= '0;
    end else if (clr_i) begin
      valid_o <= '0;
    end else if (wr_i) begin
      data_o[off_i]  <= data_i;
      valid_o[off_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 6,
  localparam int PAGE_W     = ADDR_W - OFF_W,
  localparam int PAGE_BYTES = 1 << OFF_W,
  localparam int DEPTH      = 1 << ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [7:0]                 rd_data_o,
  input  logic                       commit_i,
  input  logic [PAGE_W-1:0]          page_i,
  input  logic [PAGE_BYTES-1:0][7:0] buf_data_i,
  input  logic [PAGE_BYTES-1:0]      buf_valid_i
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int k = 0; k < PAGE_BYTES; k++)
        if (buf_valid_i[k]) mem_q[{page_i, OFF_W'(k)}] <= buf_data_i[k];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int OFF_W     = 6,
  parameter int WIN_CYC   = 30,
  parameter int START_CYC = 100,
  parameter int PROG_CYC  = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              prot_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              rdy_o,
  output logic              rdy_oe_o
);
  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int WIN_W      = $clog2(WIN_CYC + 2);
  localparam int START_W    = $clog2(START_CYC + 1);
  localparam int PROG_W     = $clog2(PROG_CYC + 1);

  ctrl_state_e          state_q;
  logic [PAGE_W-1:0]    page_q;
  logic [OFF_W-1:0]     off_q;
  logic [7:0]           data_q;
  logic                 acc_q, loaded_q, last7_q, tog_q;
  logic [WIN_W-1:0]     win_q;
  logic [START_W-1:0]   idle_q;
  logic [PROG_W-1:0]    prog_cnt_q;

  logic stb_lvl, rd_lvl, stb_start, stb_end, rd_end;
  logic accept, load, commit, abort, prog;
  logic [PAGE_BYTES-1:0][7:0] buf_data;
  logic [PAGE_BYTES-1:0]      buf_valid;
  logic [7:0]                 arr_data;

  assign stb_lvl = ~ce_ni & ~we_ni & oe_ni;
  assign rd_lvl  = ~ce_ni & ~oe_ni & we_ni & prot_ni;
  assign prog    = (state_q == ST_PROG);

  eeprom_strobe_det i_det (
    .clk_i, .rst_ni,
    .stb_i      (stb_lvl),
    .rd_i       (rd_lvl),
    .stb_start_o(stb_start),
    .stb_end_o  (stb_end),
    .rd_end_o   (rd_end)
  );

  assign accept = stb_start & prot_ni &
                  ((state_q == ST_IDLE) ||
                   (state_q == ST_LOAD && win_q <= WIN_W'(WIN_CYC)));
  assign load   = stb_end & acc_q & prot_ni & (state_q == ST_LOAD);
  assign commit = prog & prot_ni & (prog_cnt_q == PROG_W'(PROG_CYC - 1));
  assign abort  = ~prot_ni & (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      page_q     <= '0;
      off_q      <= '0;
      data_q     <= '0;
      acc_q      <= 1'b0;
      loaded_q   <= 1'b0;
      last7_q    <= 1'b0;
      tog_q      <= 1'b1;
      win_q      <= '0;
      idle_q     <= '0;
      prog_cnt_q <= '0;
    end else begin
      if (stb_lvl) data_q <= data_i;
      if (stb_end) acc_q <= 1'b0;
      if (win_q <= WIN_W'(WIN_CYC)) win_q <= win_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_LOAD;
          page_q   <= addr_i[ADDR_W-1:OFF_W];
          off_q    <= addr_i[OFF_W-1:0];
          acc_q    <= 1'b1;
          win_q    <= '0;
          loaded_q <= 1'b0;
          idle_q   <= '0;
        end
        ST_LOAD: begin
          if (accept) begin
            off_q <= addr_i[OFF_W-1:0];
            acc_q <= 1'b1;
            win_q <= '0;
          end
          if (load) begin
            last7_q  <= data_q[7];
            loaded_q <= 1'b1;
            idle_q   <= '0;
          end else if (loaded_q && !stb_lvl) begin
            if (idle_q == START_W'(START_CYC - 1)) begin
              state_q    <= ST_PROG;
              prog_cnt_q <= '0;
              tog_q      <= 1'b1;
            end else begin
              idle_q <= idle_q + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (rd_end) tog_q <= ~tog_q;
          if (commit) state_q <= ST_IDLE;
          else prog_cnt_q <= prog_cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (!prot_ni) begin
        state_q <= ST_IDLE;
        acc_q   <= 1'b0;
      end
    end
  end

  eeprom_page_buf #(.OFF_W(OFF_W)) i_buf (
    .clk_i, .rst_ni,
    .clr_i  (commit | abort),
    .wr_i   (load),
    .off_i  (off_q),
    .data_i (data_q),
    .data_o (buf_data),
    .valid_o(buf_valid)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_arr (
    .clk_i, .rst_ni,
    .rd_addr_i  (addr_i),
    .rd_data_o  (arr_data),
    .commit_i   (commit),
    .page_i     (page_q),
    .buf_data_i (buf_data),
    .buf_valid_i(buf_valid)
  );

  assign data_o    = prog ? {~last7_q, tog_q, 6'b0} : arr_data;
  assign data_oe_o = rd_lvl;
  assign rdy_o     = 1'b0;
  assign rdy_oe_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/eeprom_page_chk.sv
module eeprom_page_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       we_ni,
  input logic       oe_ni,
  input logic       prot_ni,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       rdy_oe_o,
  input logic       prog_i,
  input logic       last7_i
);
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_ni |=> !rdy_oe_o);

  p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_oe_o) |-> $past(!ce_ni && !we_ni && oe_ni && prot_ni));

  p_prog_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |-> rdy_oe_o);

  p_status_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i && $past(prog_i) && data_oe_o && $past(data_oe_o) |-> $stable(data_o));

  p_poll_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i && data_oe_o |-> data_o[7] != last7_i);

  p_no_load_in_prog_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i && $past(prog_i) |-> $stable(last7_i));
endmodule

bind eeprom_page_ctrl eeprom_page_chk i_chk (
  .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .prot_ni,
  .data_o, .data_oe_o, .rdy_oe_o,
  .prog_i (state_q == eeprom_pkg::ST_PROG),
  .last7_i(last7_q)
);

// File: tb/test_eeprom_page_ctrl.sv
module test_eeprom_page_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;
  localparam int WIN_CYC = 8;
  localparam int START_CYC = 20;
  localparam int PROG_CYC = 60;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1, prot_ni = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] data_o;
  logic data_oe_o, rdy_o, rdy_oe_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_ctrl #(.ADDR_W(ADDR_W), .WIN_CYC(WIN_CYC), .START_CYC(START_CYC),
                     .PROG_CYC(PROG_CYC)) i_eeprom_page_ctrl (
    .clk_i(clk), .rst_ni, .ce_ni, .we_ni, .oe_ni, .prot_ni,
    .addr_i(addr), .data_i(din), .data_o, .data_oe_o, .rdy_o, .rdy_oe_o);

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_s;
  event       ev_smp;

  initial forever begin
    @(ev_smp);
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL scoreboard empty act=%h", act_s);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (act_s !== e) begin
        errors++;
        $display("FAIL %s data act=%h exp=%h", t, act_s, e);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", t, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic oe_lvl);
    addr = a; din = d; oe_ni = oe_lvl; ce_ni = 1'b0; we_ni = 1'b0;
    cyc(2);
    we_ni = 1'b1; ce_ni = 1'b1; oe_ni = 1'b1;
    cyc(1);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
    addr = a; ce_ni = 1'b0; oe_ni = 1'b0;
    cyc(1);
    exp_q.push_back(e); tag_q.push_back(t);
    chk(data_oe_o, 1'b1, {t, " data_oe_o"});
    act_s = data_o;
    -> ev_smp;
    cyc(1);
    oe_ni = 1'b1; ce_ni = 1'b1;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    chk(data_oe_o, 1'b0, "R1 reset data_oe_o");
    chk(rdy_oe_o, 1'b0, "R1 reset rdy_oe_o");
    rd(11'h005, 8'hFF, "R1/R10 erased read");

    // page 2 load, second byte addressed to page 5 (R2), offset 1 twice (R5)
    wr(11'h080, 8'h11, 1'b1);
    chk(rdy_oe_o, 1'b1, "R8 busy after first strobe");
    chk(rdy_o, 1'b0, "R8 busy level low");
    wr(11'h081, 8'h22, 1'b1);
    wr(11'h141, 8'h33, 1'b1);
    wr(11'h085, 8'hA5, 1'b1);
    cyc(12);
    wr(11'h086, 8'h77, 1'b1);            // R4 late byte
    cyc(START_CYC + 4);
    chk(rdy_oe_o, 1'b1, "R5 internal write busy");
    rd(11'h080, 8'h40, "R6/R7 poll first");
    rd(11'h080, 8'h00, "R7 poll second");
    rd(11'h080, 8'h40, "R7 poll third");
    wr(11'h090, 8'h99, 1'b1);            // R3 ignored during write
    cyc(PROG_CYC + 5);
    chk(rdy_oe_o, 1'b0, "R8 released after write");
    rd(11'h080, 8'h11, "R5 byte0");
    rd(11'h081, 8'h33, "R2/R5 last value kept");
    rd(11'h085, 8'hA5, "R5 byte5");
    rd(11'h082, 8'hFF, "R5 unloaded byte");
    rd(11'h086, 8'hFF, "R4 late byte ignored");
    rd(11'h090, 8'hFF, "R3 strobe during write ignored");
    rd(11'h141, 8'hFF, "R2 other page untouched");

    // R3: strobe with oe low
    wr(11'h100, 8'h55, 1'b0);
    chk(rdy_oe_o, 1'b0, "R3 oe-low strobe no busy");
    cyc(START_CYC + 4);
    rd(11'h100, 8'hFF, "R3 oe-low strobe no write");

    // R6 with bit7 clear
    wr(11'h0C2, 8'h3C, 1'b1);
    cyc(START_CYC + 4);
    rd(11'h0C2, 8'hC0, "R6 poll bit7 clear");
    cyc(PROG_CYC + 5);
    rd(11'h0C2, 8'h3C, "R6 written");

    // R9 protect
    prot_ni = 1'b0;
    addr = 11'h0C2; ce_ni = 1'b0; oe_ni = 1'b0;
    cyc(1);
    chk(data_oe_o, 1'b0, "R9 read blocked");
    ce_ni = 1'b1; oe_ni = 1'b1;
    cyc(1);
    wr(11'h0C1, 8'h12, 1'b1);
    chk(rdy_oe_o, 1'b0, "R9 strobe blocked");
    prot_ni = 1'b1;
    cyc(1);
    wr(11'h0C0, 8'h5A, 1'b1);
    cyc(START_CYC + 4);
    chk(rdy_oe_o, 1'b1, "R9 write started");
    prot_ni = 1'b0;
    cyc(2);
    chk(rdy_oe_o, 1'b0, "R9 abort releases busy");
    prot_ni = 1'b1;
    cyc(PROG_CYC + 5);
    rd(11'h0C0, 8'hFF, "R9 aborted write");
    rd(11'h0C1, 8'hFF, "R9 blocked strobe");

    cyc(2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        cyc(200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule